// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block watches eight external interrupt pins and turns chosen events on them into sticky request flags. Each pin is first resynchronised to the core clock. It is then sensed in one of two ways: as a low level, or as an edge. An edge can be falling, rising or either. A flag that has been raised stays up until it is cleared. It is visible both on a per-pin request output and in a status register.

A small register bus reaches three registers: the edge selection, the level/edge mode and the status flags. Software may only drop a flag after it has seen that flag as 1 in a status read. After that read, writing 0 to the flag clears it. Two other sources can also clear a flag. The first is the interrupt exception logic, through one acknowledge strobe per pin. The second is a data-transfer controller that was started by the pin's request. In level mode, an acknowledge only clears the flag while the synchronised input is high. A transfer start only clears the flag when its per-pin disable-select input is 0.

Top module: `ext_irq_detect`

## Requirements
- R1: Register address 0 holds a 2-bit edge code for pin n at bits [2n+1:2n]. Code 00 raises the flag on a falling edge, 01 on a rising edge, and 10 on either edge. All fields reset to 00.
- R2: A write that puts 11 into a field of address 0 leaves that field at its old value. Legal codes in the same write still take effect. A field never holds 11.
- R3: Register address 1, bit n = 1 selects low-level sensing for pin n. The flag is raised on every cycle in which the synchronised pin is low. The register resets to 0, which means edge sensing.
- R4: Register address 2 is the status register. The flag of pin n is at bit 7-n. Bits 15:8 always read 0 and are not affected by writes. Address 3 reads 0.
- R5: Writing 0 to a status bit clears the flag only if a status read returned that flag as 1 since it was last raised. Writing 1 has no effect. Once a flag is cleared, a new read is needed before software can clear it again.
- R6: In edge sensing, a one-cycle exc_ack[n] pulse clears flag n.
- R7: In level sensing, exc_ack[n] clears flag n only while the synchronised pin is high. While the pin is low the flag stays set.
- R8: A xfer_start[n] pulse clears flag n when xfer_dis_sel[n] is 0. It has no effect when xfer_dis_sel[n] is 1.
- R9: If a set condition and a clear condition reach the same flag in the same cycle, the flag ends up set.
- R10: irq_req[n] equals flag n. After reset every flag is 0. Pins that are high during and after reset raise no flag. The first flag change comes three clock edges after the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | 8 | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 edge codes, 1 mode, 2 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| exc_ack | input | 8 | Per-pin acknowledge from exception processing |
| xfer_start | input | 8 | Per-pin transfer-controller start strobe |
| xfer_dis_sel | input | 8 | Per-pin disable-select bit that goes with xfer_start |
| irq_req | output | 8 | Per-pin interrupt request, equal to the flag |

## Verification
Some properties are checked on every cycle. The reserved status bits must read 0. The reversed bit order in status reads must match irq_req. No edge field may ever hold the illegal code. A flag may only fall after a clear source appeared in the previous cycle. A flag that has not been armed must survive a software write of 0. The edge polarities, the mode-dependent acknowledge rule, the transfer-start gating and set-over-clear priority all depend on ordered stimulus. Only the directed bench scenarios can show those.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int unsigned BUS_W  = 16;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [1:0] {
        SEL_FALL = 2'b00,
        SEL_RISE = 2'b01,
        SEL_BOTH = 2'b10,
        SEL_BAD  = 2'b11
    } edge_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_EDGE = 2'd0,
        ADDR_MODE = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int unsigned N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] cur_o,
    output logic [N_PINS-1:0] prev_o
);
    typedef struct packed {
        logic [N_PINS-1:0] meta;
        logic [N_PINS-1:0] cur;
        logic [N_PINS-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    // reset high so an idle-high pin shows no edge when reset drops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.cur;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cur_i,
    input  logic       prev_i,
    input  logic [1:0] edge_sel_i,
    input  logic       level_i,
    input  logic       stat_rd_i,
    input  logic       stat_wr_i,
    input  logic       wbit_i,
    input  logic       exc_ack_i,
    input  logic       xfer_start_i,
    input  logic       xfer_dis_i,
    output logic       flag_o,
    output logic       armed_o
);
    typedef struct packed {
        logic flag;
        logic armed;
    } cell_t;

    cell_t st_d, st_q;
    logic  edge_hit, set_c, clr_c;

    always_comb begin
        unique case (edge_sel_e'(edge_sel_i))
            SEL_FALL: edge_hit = prev_i & ~cur_i;
            SEL_RISE: edge_hit = ~prev_i & cur_i;
            SEL_BOTH: edge_hit = prev_i ^ cur_i;
            default:  edge_hit = 1'b0;
        endcase
        set_c = level_i ? ~cur_i : edge_hit;
        clr_c = (exc_ack_i & (~level_i | cur_i))
              | (xfer_start_i & ~xfer_dis_i)
              | (stat_wr_i & ~wbit_i & st_q.armed);

        st_d = st_q;
        if (stat_rd_i && st_q.flag) st_d.armed = 1'b1;
        if (set_c) begin
            st_d.flag = 1'b1;
        end else if (clr_c) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o  = st_q.flag;
    assign armed_o = st_q.armed;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int unsigned N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] irq_pin,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [N_PINS-1:0] exc_ack,
    input  logic [N_PINS-1:0] xfer_start,
    input  logic [N_PINS-1:0] xfer_dis_sel,
    output logic [N_PINS-1:0] irq_req
);
    localparam int unsigned SEL_W = 2 * N_PINS;

    typedef struct packed {
        logic [SEL_W-1:0]  edge_sel;
        logic [N_PINS-1:0] level;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [N_PINS-1:0] cur_w, prev_w, flag_w, armed_w;
    logic [SEL_W-1:0]  edge_sel_w;
    logic              stat_rd, stat_wr;

    assign stat_rd = bus_sel & ~bus_wr & (bus_addr == ADDR_STAT);
    assign stat_wr = bus_sel &  bus_wr & (bus_addr == ADDR_STAT);

    irq_pin_sync #(.N_PINS(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (irq_pin),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (bus_sel && bus_wr) begin
            if (bus_addr == ADDR_EDGE) begin
                for (int i = 0; i < N_PINS; i++) begin
                    if (bus_wdata[2*i +: 2] != SEL_BAD)
                        cfg_d.edge_sel[2*i +: 2] = bus_wdata[2*i +: 2];
                end
            end
            if (bus_addr == ADDR_MODE) cfg_d.level = bus_wdata[N_PINS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign edge_sel_w = cfg_q.edge_sel;

    for (genvar g = 0; g < N_PINS; g++) begin : g_cell
        irq_flag_cell u_cell (
            .clk          (clk),
            .rst_n        (rst_n),
            .cur_i        (cur_w[g]),
            .prev_i       (prev_w[g]),
            .edge_sel_i   (cfg_q.edge_sel[2*g +: 2]),
            .level_i      (cfg_q.level[g]),
            .stat_rd_i    (stat_rd),
            .stat_wr_i    (stat_wr),
            .wbit_i       (bus_wdata[N_PINS-1-g]),
            .exc_ack_i    (exc_ack[g]),
            .xfer_start_i (xfer_start[g]),
            .xfer_dis_i   (xfer_dis_sel[g]),
            .flag_o       (flag_w[g]),
            .armed_o      (armed_w[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (reg_addr_e'(bus_addr))
            ADDR_EDGE: bus_rdata[SEL_W-1:0]  = cfg_q.edge_sel;
            ADDR_MODE: bus_rdata[N_PINS-1:0] = cfg_q.level;
            ADDR_STAT: begin
                for (int i = 0; i < N_PINS; i++)
                    bus_rdata[N_PINS-1-i] = flag_w[i];
            end
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_req = flag_w;
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
    parameter int unsigned N_PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic [N_PINS-1:0] irq_req,
    input logic [N_PINS-1:0] exc_ack,
    input logic [N_PINS-1:0] xfer_start,
    input logic [N_PINS-1:0] armed,
    input logic [2*N_PINS-1:0] edge_sel
);
    logic st_rd, st_wr;
    assign st_rd = bus_sel && !bus_wr && bus_addr == 2'd2;
    assign st_wr = bus_sel &&  bus_wr && bus_addr == 2'd2;

    assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd |-> bus_rdata[15:8] == 8'h00);

    assert_req_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd |-> bus_rdata[7:0] == {<<{irq_req}});

    assert_no_stray_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~irq_req & $past(irq_req))) |->
            $past((|exc_ack) || (|xfer_start) || st_wr));

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
            edge_sel[2*g +: 2] != 2'b11);

        assert_unarmed_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[g] && !armed[g] && st_wr && !bus_wdata[N_PINS-1-g]
             && !exc_ack[g] && !xfer_start[g]) |=> irq_req[g]);
    end
endmodule

bind ext_irq_detect ext_irq_detect_chk #(.N_PINS(N_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_req    (irq_req),
    .exc_ack    (exc_ack),
    .xfer_start (xfer_start),
    .armed      (armed_w),
    .edge_sel   (edge_sel_w)
);

// File: tb/ext_irq_detect_tb.sv
module ext_irq_detect_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  irq_pin;
    logic        bus_sel, bus_wr;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic [7:0]  exc_ack, xfer_start, xfer_dis_sel, irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ext_irq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .exc_ack(exc_ack), .xfer_start(xfer_start),
        .xfer_dis_sel(xfer_dis_sel), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_pin = '1; bus_sel = 0; bus_wr = 0; bus_addr = 0;
        bus_wdata = 0; exc_ack = 0; xfer_start = 0; xfer_dis_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic pin(input int n, input logic v);
        @(negedge clk); irq_pin[n] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack(input int n);
        @(negedge clk); exc_ack[n] = 1;
        @(negedge clk); exc_ack[n] = 0;
        #1;
    endtask

    task automatic xstart(input int n, input logic dis);
        @(negedge clk); xfer_start[n] = 1; xfer_dis_sel[n] = dis;
        @(negedge clk); xfer_start[n] = 0; xfer_dis_sel[n] = 0;
        #1;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        repeat (4) @(negedge clk);
        chk("R10 req after reset", {8'h0, irq_req}, 16'h0);
        rd(2'd2, d); chk("R4 status after reset", d, 16'h0);
        rd(2'd0, d); chk("R1 edge reg reset", d, 16'h0);
        rd(2'd1, d); chk("R3 mode reg reset", d, 16'h0);
    endtask

    task automatic t_latency();
        do_reset();
        @(negedge clk); irq_pin[2] = 0;
        repeat (2) @(negedge clk);
        chk("R10 no flag after two edges", {15'h0, irq_req[2]}, 16'h0);
        @(negedge clk);
        chk("R10 flag after three edges", {15'h0, irq_req[2]}, 16'h1);
    endtask

    task automatic t_falling();
        logic [15:0] d;
        do_reset();
        pin(3, 0); pin(3, 1);
        chk("R1 falling sel: rising pin3 no extra", {8'h0, irq_req}, 16'h0008);
        ack(3);
        pin(2, 0);
        chk("R1 falling sets pin2", {8'h0, irq_req}, 16'h0004);
        rd(2'd2, d); chk("R4 pin2 at bit5", d, 16'h0020);
    endtask

    task automatic t_rising();
        do_reset();
        wr(2'd0, 16'h0100);
        pin(4, 0);
        chk("R1 rising sel ignores fall", {8'h0, irq_req}, 16'h0);
        pin(4, 1);
        chk("R1 rising sel sets on rise", {8'h0, irq_req}, 16'h0010);
    endtask

    task automatic t_both();
        do_reset();
        wr(2'd0, 16'h2000);
        pin(6, 0);
        chk("R1 both sel fall", {8'h0, irq_req}, 16'h0040);
        ack(6);
        chk("R6 ack clears edge flag", {8'h0, irq_req}, 16'h0);
        pin(6, 1);
        chk("R1 both sel rise", {8'h0, irq_req}, 16'h0040);
    endtask

    task automatic t_illegal();
        logic [15:0] d;
        do_reset();
        wr(2'd0, 16'h0004);
        wr(2'd0, 16'h100C);
        rd(2'd0, d); chk("R2 illegal code kept old, legal applied", d, 16'h1004);
        pin(1, 0);
        chk("R2 pin1 still rising: no fall flag", {8'h0, irq_req}, 16'h0);
        pin(1, 1);
        chk("R2 pin1 rising sets", {8'h0, irq_req}, 16'h0002);
    endtask

    task automatic t_status();
        logic [15:0] d;
        do_reset();
        pin(0, 0);
        wr(2'd2, 16'hFF80);
        rd(2'd2, d); chk("R4 reserved read 0, write 1 no effect", d, 16'h0080);
        rd(2'd3, d); chk("R4 unused address reads 0", d, 16'h0);
    endtask

    task automatic t_swclear();
        logic [15:0] d;
        do_reset();
        pin(0, 0);
        wr(2'd2, 16'h0000);
        chk("R5 write 0 unread keeps flag", {8'h0, irq_req}, 16'h0001);
        rd(2'd2, d); chk("R5 read shows flag", d, 16'h0080);
        wr(2'd2, 16'h0000); #1;
        chk("R5 write 0 after read clears", {8'h0, irq_req}, 16'h0);
        pin(0, 1); pin(0, 0);
        wr(2'd2, 16'h0000); #1;
        chk("R5 arm dropped on clear", {8'h0, irq_req}, 16'h0001);
    endtask

    task automatic t_level();
        do_reset();
        wr(2'd1, 16'h0008);
        pin(3, 0);
        chk("R3 low level sets", {8'h0, irq_req}, 16'h0008);
        ack(3);
        chk("R7 ack while low keeps", {8'h0, irq_req}, 16'h0008);
        pin(3, 1);
        chk("R3 flag sticky after high", {8'h0, irq_req}, 16'h0008);
        ack(3);
        chk("R7 ack while high clears", {8'h0, irq_req}, 16'h0);
    endtask

    task automatic t_xfer();
        do_reset();
        pin(5, 0);
        xstart(5, 1'b1);
        chk("R8 start with disable-select 1 keeps", {8'h0, irq_req}, 16'h0020);
        xstart(5, 1'b0);
        chk("R8 start with disable-select 0 clears", {8'h0, irq_req}, 16'h0);
    endtask

    task automatic t_setwins();
        do_reset();
        wr(2'd1, 16'h0020);
        pin(5, 0);
        xstart(5, 1'b0);
        chk("R9 set beats clear", {8'h0, irq_req}, 16'h0020);
        pin(5, 1);
        xstart(5, 1'b0);
        chk("R9 clear once set gone", {8'h0, irq_req}, 16'h0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_falling();
        t_rising();
        t_both();
        t_illegal();
        t_status();
        t_swclear();
        t_level();
        t_xfer();
        t_setwins();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule